// File: doc/BRIEF.md
# Two-Wire Camera Control Register Slave

This block is the control-port slave of an image sensor. A host drives the clock of a two-wire bus at up to 100 kHz. The data line is open-drain, and the block can only pull it low. Through this port the host programs the sensor's configuration registers and reads back a 32-bit status word. Both bus lines pass through two synchronising flops into the system clock domain. A start or a stop is seen as a data edge while the clock is high.

The 7-bit address has `00100` in its upper five bits. The two lowest bits come from strap pins, so up to four sensors can share one bus. A write message is the address byte followed by exactly two bytes. The first of these carries a 4-bit header that selects the register, plus bits 11:8 of a 12-bit payload. The second byte carries payload bits 7:0. A read message returns four bytes, most significant first.

Writes to coarse exposure, fine exposure and gain are staged. They take effect only on the next frame-start strobe. Until that strobe arrives, the block refuses every address, for reads and writes alike.

Top module: `cam2w_slave`

## Requirements
- R1: The block acknowledges (pulls data low during the ninth clock) an address byte whose upper seven bits equal `00100` followed by `strap_i[1]`, `strap_i[0]`. Any other address gets no acknowledge, and the block ignores the rest of that message.
- R2: A write carries header in bits 7:4 and payload bits 11:8 in the first data byte, then payload bits 7:0 in the second. The block acknowledges each byte. Header 1 loads setup 1, 2 loads setup 2, 8 loads threshold 1, 9 loads threshold 2, 10 loads analog control and 14 loads setup 3. Each load is visible on that register's port.
- R3: Headers 0, 6, 7, 11, 12, 13 and 15 change no register.
- R4: The payload is packed toward bit 0, and bits above a register's width are dropped. Gain keeps payload bits 3:0, the thresholds keep bits 7:0, and the exposures keep bits 8:0.
- R5: Header 3 (coarse exposure), header 4 (fine exposure) and header 5 (gain) stage their value. The output ports keep the old value until the cycle after `frame_start_i` is high, and then take the staged value.
- R6: While any staged value waits for a frame start, the block acknowledges no address byte, for read or write. Normal operation resumes after the frame start.
- R7: A read returns the primary word, MSB first, when setup 2 bit 0 is 0. The word is laid out as follows:
  - bits 31:23: coarse exposure
  - bits 22:14: fine exposure
  - bits 13:10: gain
  - bit 9: setup 1 bit 1 (auto exposure)
  - bit 8: setup 1 bit 3 (force black calibration)
  - bit 7: setup 1 bit 2 (auto gain)
  - bit 6: setup 1 bit 4 (linear output)
  - bit 5: `backlit_pin_i`
  - bit 4: 0
  - bits 3:0: the type ID (default 5)
- R8: When setup 2 bit 0 is 1, a read returns the secondary word instead: `blm_busy_i` in bit 17, `wpix_count_i` in bits 16:0, and zeros above.
- R9: After reset, setup 1 holds `0x00E` (bits 1, 2 and 3 set), and every other register is 0.
- R10: Setup 1 bits 9:8 select a clock division ratio of 1, 2, 4 or 8 for codes 0 to 3. The ratio is shown on `clk_div_o`.
- R11: After the second data byte of a write and its acknowledge, the block returns to idle even if no stop follows. Further bytes clocked before the next start are neither acknowledged nor written.
- R12: During a read, the block releases the data line for the master's acknowledge after each byte. A master not-acknowledge ends the read, and the line stays released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Bus clock from the host |
| sda_i | input | 1 | Bus data level as seen on the wire |
| sda_pull_o | output | 1 | High to pull the data line low |
| strap_i | input | 2 | Lowest two address bits |
| frame_start_i | input | 1 | One-cycle frame-start strobe |
| backlit_pin_i | input | 1 | Backlit mode pin level, reported in the status word |
| blm_busy_i | input | 1 | Black-level monitor busy flag |
| wpix_count_i | input | 17 | White-pixel count |
| setup1_o | output | 12 | Setup 1 register |
| setup2_o | output | 12 | Setup 2 register |
| setup3_o | output | 12 | Setup 3 register |
| coarse_exp_o | output | 9 | Applied coarse exposure |
| fine_exp_o | output | 9 | Applied fine exposure |
| gain_o | output | 4 | Applied gain |
| thr1_o | output | 8 | Threshold 1 |
| thr2_o | output | 8 | Threshold 2 |
| ana_ctl_o | output | 12 | Analog control register |
| clk_div_o | output | 4 | Decoded clock division ratio |

## Verification
The hardest state to reach is the one where a staged exposure or gain write is pending. In that state the block must turn away its own address, and it must never refuse a later message once the frame start arrives. The bench writes coarse exposure and keeps the frame-start strobe low. It then tries both a read and a write to the correct address, and checks that neither is acknowledged and that the output port has not moved. Only then does it pulse the strobe and confirm that the value lands and that the address is accepted again. A second hard case is a write that keeps clocking bytes without a stop. The bench continues past the second data byte with a byte that would be a valid header, and checks the missing acknowledge and the untouched register.

// File: rtl/cam2w_pkg.sv
// Shared definitions for the two-wire camera register slave.
// Assumes a 4-bit header selects a register inside a 12-bit payload word.
package cam2w_pkg;

    localparam int HDR_W = 4;
    localparam int PAY_W = 12;
    localparam int WORD_W = 32;

    // Register select codes carried in the header nibble
    localparam logic [HDR_W-1:0] HDR_SETUP1 = 4'h1;
    localparam logic [HDR_W-1:0] HDR_SETUP2 = 4'h2;
    localparam logic [HDR_W-1:0] HDR_COARSE = 4'h3;
    localparam logic [HDR_W-1:0] HDR_FINE = 4'h4;
    localparam logic [HDR_W-1:0] HDR_GAIN = 4'h5;
    localparam logic [HDR_W-1:0] HDR_THR1 = 4'h8;
    localparam logic [HDR_W-1:0] HDR_THR2 = 4'h9;
    localparam logic [HDR_W-1:0] HDR_ANA = 4'hA;
    localparam logic [HDR_W-1:0] HDR_SETUP3 = 4'hE;

    // Setup 1 field positions
    localparam int S1_AE = 1;
    localparam int S1_AG = 2;
    localparam int S1_BLK = 3;
    localparam int S1_LIN = 4;
    localparam int S1_DIV_LO = 8;
    localparam logic [PAY_W-1:0] SETUP1_RST = 12'h00E;

    typedef enum logic [2:0] {
        LK_IDLE,
        LK_ADDR,
        LK_ADDR_ACK,
        LK_WR_BYTE,
        LK_WR_ACK,
        LK_RD_BYTE,
        LK_RD_ACK
    } link_state_t;

endpackage

// File: rtl/cam2w_sync.sv
// Brings the bus clock and data into the system clock domain and flags
// clock edges plus start and stop conditions.
// Assumes the system clock is many times faster than the bus clock.
module cam2w_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_rise_o,
    output logic scl_fall_o,
    output logic start_o,
    output logic stop_o,
    output logic sda_lvl_o
);
    localparam int PW = STAGES + 1;

    logic [PW-1:0] scl_pipe;
    logic [PW-1:0] sda_pipe;

    // Synchroniser chain plus one delay stage for edge detection; idle bus is high
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_pipe <= '1;
            sda_pipe <= '1;
        end else begin
            scl_pipe <= {scl_pipe[PW-2:0], scl_i};
            sda_pipe <= {sda_pipe[PW-2:0], sda_i};
        end
    end

    logic scl_s, scl_d, sda_s, sda_d;
    assign scl_s = scl_pipe[PW-2];
    assign scl_d = scl_pipe[PW-1];
    assign sda_s = sda_pipe[PW-2];
    assign sda_d = sda_pipe[PW-1];

    assign scl_rise_o = scl_s & ~scl_d;
    assign scl_fall_o = ~scl_s & scl_d;
    assign start_o = scl_s & scl_d & sda_d & ~sda_s;
    assign stop_o = scl_s & scl_d & ~sda_d & sda_s;
    assign sda_lvl_o = sda_s;

endmodule

// File: rtl/cam2w_link.sv
// Bit-level protocol engine: address match, acknowledges, the fixed two-byte
// write and the four-byte read.
// Assumes edge and condition flags from cam2w_sync; drives data only while clock is low.
module cam2w_link
    import cam2w_pkg::*;
#(
    parameter logic [4:0] ADDR_HI = 5'b00100
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_rise_i,
    input  logic              scl_fall_i,
    input  logic              start_i,
    input  logic              stop_i,
    input  logic              sda_lvl_i,
    input  logic [1:0]        strap_i,
    input  logic              hold_i,
    input  logic [WORD_W-1:0] rd_word_i,
    output logic              sda_pull_o,
    output logic              wr_stb_o,
    output logic [HDR_W-1:0]  wr_hdr_o,
    output logic [PAY_W-1:0]  wr_data_o
);
    localparam int BITS = 8;
    localparam int RD_BYTES = WORD_W / BITS;
    localparam int BC_W = $clog2(BITS + 1);
    localparam int BY_W = $clog2(RD_BYTES);

    link_state_t       state_q;
    logic [BC_W-1:0]   bitcnt_q;
    logic [BY_W-1:0]   bytecnt_q;
    logic [BITS-1:0]   shreg_q;
    logic [WORD_W-1:0] rd_sh_q;
    logic              rw_q;
    logic              mack_q;
    logic [3:0]        data_hi_q;
    logic              addr_hit;

    assign addr_hit = (shreg_q[7:1] == {ADDR_HI, strap_i});

    // Protocol state machine advanced on synchronised bus events
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= LK_IDLE;
            bitcnt_q   <= '0;
            bytecnt_q  <= '0;
            shreg_q    <= '0;
            rd_sh_q    <= '0;
            rw_q       <= 1'b0;
            mack_q     <= 1'b1;
            data_hi_q  <= '0;
            sda_pull_o <= 1'b0;
            wr_stb_o   <= 1'b0;
            wr_hdr_o   <= '0;
            wr_data_o  <= '0;
        end else begin
            wr_stb_o <= 1'b0;
            if (start_i) begin
                state_q    <= LK_ADDR;
                bitcnt_q   <= '0;
                sda_pull_o <= 1'b0;
            end else if (stop_i) begin
                state_q    <= LK_IDLE;
                sda_pull_o <= 1'b0;
            end else begin
                case (state_q)
                    LK_ADDR: begin
                        if (scl_rise_i) begin
                            shreg_q  <= {shreg_q[BITS-2:0], sda_lvl_i};
                            bitcnt_q <= bitcnt_q + 1'b1;
                        end else if (scl_fall_i && bitcnt_q == BC_W'(BITS)) begin
                            if (addr_hit && !hold_i) begin
                                sda_pull_o <= 1'b1;
                                rw_q       <= shreg_q[0];
                                state_q    <= LK_ADDR_ACK;
                            end else begin
                                state_q <= LK_IDLE;
                            end
                        end
                    end
                    LK_ADDR_ACK: begin
                        if (scl_fall_i) begin
                            bitcnt_q  <= '0;
                            bytecnt_q <= '0;
                            if (rw_q) begin
                                rd_sh_q    <= rd_word_i;
                                sda_pull_o <= ~rd_word_i[WORD_W-1];
                                state_q    <= LK_RD_BYTE;
                            end else begin
                                sda_pull_o <= 1'b0;
                                state_q    <= LK_WR_BYTE;
                            end
                        end
                    end
                    LK_WR_BYTE: begin
                        if (scl_rise_i) begin
                            shreg_q  <= {shreg_q[BITS-2:0], sda_lvl_i};
                            bitcnt_q <= bitcnt_q + 1'b1;
                        end else if (scl_fall_i && bitcnt_q == BC_W'(BITS)) begin
                            sda_pull_o <= 1'b1;
                            state_q    <= LK_WR_ACK;
                            if (bytecnt_q == '0) begin
                                wr_hdr_o  <= shreg_q[7:4];
                                data_hi_q <= shreg_q[3:0];
                            end else begin
                                wr_data_o <= {data_hi_q, shreg_q};
                                wr_stb_o  <= 1'b1;
                            end
                        end
                    end
                    LK_WR_ACK: begin
                        if (scl_fall_i) begin
                            sda_pull_o <= 1'b0;
                            if (bytecnt_q != '0) begin
                                state_q <= LK_IDLE;
                            end else begin
                                bytecnt_q <= bytecnt_q + 1'b1;
                                bitcnt_q  <= '0;
                                state_q   <= LK_WR_BYTE;
                            end
                        end
                    end
                    LK_RD_BYTE: begin
                        if (scl_rise_i) begin
                            bitcnt_q <= bitcnt_q + 1'b1;
                        end else if (scl_fall_i) begin
                            rd_sh_q <= {rd_sh_q[WORD_W-2:0], 1'b0};
                            if (bitcnt_q == BC_W'(BITS)) begin
                                sda_pull_o <= 1'b0;
                                state_q    <= LK_RD_ACK;
                            end else begin
                                sda_pull_o <= ~rd_sh_q[WORD_W-2];
                            end
                        end
                    end
                    LK_RD_ACK: begin
                        if (scl_rise_i) begin
                            mack_q <= sda_lvl_i;
                        end else if (scl_fall_i) begin
                            if (!mack_q && bytecnt_q != BY_W'(RD_BYTES - 1)) begin
                                bytecnt_q  <= bytecnt_q + 1'b1;
                                bitcnt_q   <= '0;
                                sda_pull_o <= ~rd_sh_q[WORD_W-1];
                                state_q    <= LK_RD_BYTE;
                            end else begin
                                state_q <= LK_IDLE;
                            end
                        end
                    end
                    default: state_q <= LK_IDLE;
                endcase
            end
        end
    end

    // R1
    bit_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bitcnt_q <= BC_W'(BITS));

    // R6
    hold_refuse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == LK_ADDR && scl_fall_i && !start_i && !stop_i &&
         bitcnt_q == BC_W'(BITS) && hold_i)
        |=> (state_q == LK_IDLE && !sda_pull_o));

    // R12
    release_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == LK_IDLE || state_q == LK_RD_ACK || state_q == LK_ADDR) |-> !sda_pull_o);

    // R11
    write_ends_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb_o |=> (state_q != LK_WR_BYTE));

endmodule

// File: rtl/cam2w_regs.sv
// Register file: decodes header writes, stages exposure and gain until frame
// start, and assembles the primary or secondary status word.
// Assumes one write strobe per completed two-byte write message.
module cam2w_regs
    import cam2w_pkg::*;
#(
    parameter int         CEXP_W  = 9,
    parameter int         FEXP_W  = 9,
    parameter int         GAIN_W  = 4,
    parameter int         THR_W   = 8,
    parameter int         CNT_W   = 17,
    parameter logic [3:0] TYPE_ID = 4'h5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_stb_i,
    input  logic [HDR_W-1:0]  wr_hdr_i,
    input  logic [PAY_W-1:0]  wr_data_i,
    input  logic              frame_start_i,
    input  logic              backlit_pin_i,
    input  logic              blm_busy_i,
    input  logic [CNT_W-1:0]  wpix_count_i,
    output logic              hold_o,
    output logic [WORD_W-1:0] rd_word_o,
    output logic [PAY_W-1:0]  setup1_o,
    output logic [PAY_W-1:0]  setup2_o,
    output logic [PAY_W-1:0]  setup3_o,
    output logic [CEXP_W-1:0] coarse_exp_o,
    output logic [FEXP_W-1:0] fine_exp_o,
    output logic [GAIN_W-1:0] gain_o,
    output logic [THR_W-1:0]  thr1_o,
    output logic [THR_W-1:0]  thr2_o,
    output logic [PAY_W-1:0]  ana_ctl_o,
    output logic [3:0]        clk_div_o
);
    localparam int NSTAGE = 3;
    localparam int SEC_PAD = WORD_W - CNT_W - 1;

    logic [CEXP_W-1:0] coarse_stg_q;
    logic [FEXP_W-1:0] fine_stg_q;
    logic [GAIN_W-1:0] gain_stg_q;
    logic [NSTAGE-1:0] pend_q;

    // Header decode, staging and frame-start application
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            setup1_o     <= SETUP1_RST;
            setup2_o     <= '0;
            setup3_o     <= '0;
            coarse_exp_o <= '0;
            fine_exp_o   <= '0;
            gain_o       <= '0;
            thr1_o       <= '0;
            thr2_o       <= '0;
            ana_ctl_o    <= '0;
            coarse_stg_q <= '0;
            fine_stg_q   <= '0;
            gain_stg_q   <= '0;
            pend_q       <= '0;
        end else begin
            if (frame_start_i) begin
                if (pend_q[0]) coarse_exp_o <= coarse_stg_q;
                if (pend_q[1]) fine_exp_o <= fine_stg_q;
                if (pend_q[2]) gain_o <= gain_stg_q;
                pend_q <= '0;
            end
            if (wr_stb_i) begin
                case (wr_hdr_i)
                    HDR_SETUP1: setup1_o <= wr_data_i;
                    HDR_SETUP2: setup2_o <= wr_data_i;
                    HDR_SETUP3: setup3_o <= wr_data_i;
                    HDR_THR1:   thr1_o <= wr_data_i[THR_W-1:0];
                    HDR_THR2:   thr2_o <= wr_data_i[THR_W-1:0];
                    HDR_ANA:    ana_ctl_o <= wr_data_i;
                    HDR_COARSE: begin
                        coarse_stg_q <= wr_data_i[CEXP_W-1:0];
                        pend_q[0]    <= 1'b1;
                    end
                    HDR_FINE: begin
                        fine_stg_q <= wr_data_i[FEXP_W-1:0];
                        pend_q[1]  <= 1'b1;
                    end
                    HDR_GAIN: begin
                        gain_stg_q <= wr_data_i[GAIN_W-1:0];
                        pend_q[2]  <= 1'b1;
                    end
                    default: ;
                endcase
            end
        end
    end

    assign hold_o = |pend_q;

    // Division ratio decode from the two setup 1 select bits
    always_comb begin
        clk_div_o = 4'd1 << setup1_o[S1_DIV_LO +: 2];
    end

    // Status word selection between primary and secondary layouts
    always_comb begin
        if (setup2_o[0]) begin
            rd_word_o = {{SEC_PAD{1'b0}}, blm_busy_i, wpix_count_i};
        end else begin
            rd_word_o = {coarse_exp_o, fine_exp_o, gain_o,
                         setup1_o[S1_AE], setup1_o[S1_BLK], setup1_o[S1_AG],
                         setup1_o[S1_LIN], backlit_pin_i, 1'b0, TYPE_ID};
        end
    end

    // R5
    coarse_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(coarse_exp_o) |-> $past(frame_start_i));

    // R5
    gain_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(gain_o) |-> $past(frame_start_i));

    // R6
    hold_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_start_i && !wr_stb_i) |=> !hold_o);

    // R6
    hold_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hold_o) |-> $past(wr_stb_i));

    // R10
    div_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(clk_div_o) && clk_div_o != 4'd0);

endmodule

// File: rtl/cam2w_slave.sv
// Top level of the two-wire camera register slave: synchroniser, protocol
// engine and register file.
// Assumes an external open-drain pad: sda_pull_o high pulls the wire low.
module cam2w_slave
    import cam2w_pkg::*;
#(
    parameter logic [4:0] ADDR_HI = 5'b00100,
    parameter int         SYNC_STAGES = 2,
    parameter logic [3:0] TYPE_ID = 4'h5
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        scl_i,
    input  logic        sda_i,
    output logic        sda_pull_o,
    input  logic [1:0]  strap_i,
    input  logic        frame_start_i,
    input  logic        backlit_pin_i,
    input  logic        blm_busy_i,
    input  logic [16:0] wpix_count_i,
    output logic [11:0] setup1_o,
    output logic [11:0] setup2_o,
    output logic [11:0] setup3_o,
    output logic [8:0]  coarse_exp_o,
    output logic [8:0]  fine_exp_o,
    output logic [3:0]  gain_o,
    output logic [7:0]  thr1_o,
    output logic [7:0]  thr2_o,
    output logic [11:0] ana_ctl_o,
    output logic [3:0]  clk_div_o
);
    logic              scl_rise, scl_fall, start_c, stop_c, sda_lvl;
    logic              hold;
    logic [WORD_W-1:0] rd_word;
    logic              wr_stb;
    logic [HDR_W-1:0]  wr_hdr;
    logic [PAY_W-1:0]  wr_data;

    cam2w_sync #(.STAGES(SYNC_STAGES)) sync_i (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .scl_rise_o(scl_rise), .scl_fall_o(scl_fall),
        .start_o(start_c), .stop_o(stop_c), .sda_lvl_o(sda_lvl)
    );

    cam2w_link #(.ADDR_HI(ADDR_HI)) link_i (
        .clk(clk), .rst_n(rst_n),
        .scl_rise_i(scl_rise), .scl_fall_i(scl_fall),
        .start_i(start_c), .stop_i(stop_c), .sda_lvl_i(sda_lvl),
        .strap_i(strap_i), .hold_i(hold), .rd_word_i(rd_word),
        .sda_pull_o(sda_pull_o), .wr_stb_o(wr_stb),
        .wr_hdr_o(wr_hdr), .wr_data_o(wr_data)
    );

    cam2w_regs #(.TYPE_ID(TYPE_ID)) regs_i (
        .clk(clk), .rst_n(rst_n),
        .wr_stb_i(wr_stb), .wr_hdr_i(wr_hdr), .wr_data_i(wr_data),
        .frame_start_i(frame_start_i), .backlit_pin_i(backlit_pin_i),
        .blm_busy_i(blm_busy_i), .wpix_count_i(wpix_count_i),
        .hold_o(hold), .rd_word_o(rd_word),
        .setup1_o(setup1_o), .setup2_o(setup2_o), .setup3_o(setup3_o),
        .coarse_exp_o(coarse_exp_o), .fine_exp_o(fine_exp_o), .gain_o(gain_o),
        .thr1_o(thr1_o), .thr2_o(thr2_o), .ana_ctl_o(ana_ctl_o),
        .clk_div_o(clk_div_o)
    );

endmodule

// File: tb/cam2w_slave_tb_top.sv
// Directed bench for cam2w_slave: one task per scenario, bus modelled as wired-AND.
module cam2w_slave_tb_top;
    localparam int Q = 8;
    localparam logic [6:0] DEV = 7'b0010010;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl = 1'b1;
    logic m_sda = 1'b1;
    logic sda_bus;
    logic sda_pull;
    logic [1:0] strap = 2'b10;
    logic frame_start = 1'b0;
    logic backlit_pin = 1'b1;
    logic blm_busy = 1'b1;
    logic [16:0] wpix = 17'h1ABCD;
    logic [11:0] setup1, setup2, setup3, ana;
    logic [8:0] coarse, fine;
    logic [3:0] gain, div;
    logic [7:0] thr1, thr2;
    int n_chk = 0;
    int n_fail = 0;

    always #2 clk = ~clk;
    assign sda_bus = m_sda & ~sda_pull;

    cam2w_slave dut_i (
        .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_bus),
        .sda_pull_o(sda_pull), .strap_i(strap), .frame_start_i(frame_start),
        .backlit_pin_i(backlit_pin), .blm_busy_i(blm_busy), .wpix_count_i(wpix),
        .setup1_o(setup1), .setup2_o(setup2), .setup3_o(setup3),
        .coarse_exp_o(coarse), .fine_exp_o(fine), .gain_o(gain),
        .thr1_o(thr1), .thr2_o(thr2), .ana_ctl_o(ana), .clk_div_o(div)
    );

    task automatic wq(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic bus_start();
        m_sda = 1'b1; wq(Q); scl = 1'b1; wq(Q); m_sda = 1'b0; wq(Q); scl = 1'b0; wq(Q);
    endtask

    task automatic bus_stop();
        m_sda = 1'b0; wq(Q); scl = 1'b1; wq(Q); m_sda = 1'b1; wq(2 * Q);
    endtask

    task automatic put_bit(input logic b);
        m_sda = b; wq(Q); scl = 1'b1; wq(2 * Q); scl = 1'b0; wq(Q);
    endtask

    task automatic get_bit(output logic b);
        m_sda = 1'b1; wq(Q); scl = 1'b1; wq(Q); b = sda_bus; wq(Q); scl = 1'b0; wq(Q);
    endtask

    task automatic send_byte(input logic [7:0] v, output logic ack);
        logic bb;
        for (int i = 7; i >= 0; i--) put_bit(v[i]);
        get_bit(bb);
        ack = ~bb;
    endtask

    task automatic recv_byte(output logic [7:0] v, input logic mack);
        logic bb;
        for (int i = 7; i >= 0; i--) begin
            get_bit(bb);
            v[i] = bb;
        end
        put_bit(~mack);
    endtask

    task automatic wr_reg(input logic [3:0] hdr, input logic [11:0] d, output logic ok);
        logic a0, a1, a2;
        bus_start();
        send_byte({DEV, 1'b0}, a0);
        send_byte({hdr, d[11:8]}, a1);
        send_byte(d[7:0], a2);
        bus_stop();
        ok = a0 & a1 & a2;
    endtask

    task automatic rd_reg(output logic [31:0] w, output logic ok);
        logic [7:0] b;
        bus_start();
        send_byte({DEV, 1'b1}, ok);
        for (int k = 0; k < 4; k++) begin
            recv_byte(b, k < 3);
            w = {w[23:0], b};
        end
        bus_stop();
    endtask

    task automatic pulse_frame();
        frame_start = 1'b1; wq(1); frame_start = 1'b0; wq(2);
    endtask

    task automatic t_reset();
        chk(setup1 == 12'h00E, "R9 setup1 reset", setup1, 12'h00E);
        chk(coarse == 0 && fine == 0 && gain == 0 && thr1 == 0 && ana == 0,
            "R9 other regs reset", {coarse, fine, gain}, 0);
        chk(div == 4'd1, "R10 reset div", div, 1);
        chk(sda_pull == 1'b0, "R12 line released at reset", sda_pull, 0);
    endtask

    task automatic t_address();
        logic a;
        bus_start();
        send_byte({7'b0010011, 1'b0}, a);
        bus_stop();
        chk(a == 1'b0, "R1 wrong address not acked", a, 0);
        bus_start();
        send_byte({7'b0110010, 1'b0}, a);
        bus_stop();
        chk(a == 1'b0, "R1 wrong upper bits not acked", a, 0);
    endtask

    task automatic t_write();
        logic ok;
        wr_reg(4'h8, 12'h0A5, ok);
        chk(ok, "R1 R2 acks on thr1 write", ok, 1);
        chk(thr1 == 8'hA5, "R2 thr1", thr1, 8'hA5);
        wr_reg(4'hA, 12'h3C7, ok);
        chk(ok && ana == 12'h3C7, "R2 analog ctl", ana, 12'h3C7);
        wr_reg(4'hE, 12'h812, ok);
        chk(ok && setup3 == 12'h812, "R2 setup3", setup3, 12'h812);
    endtask

    task automatic t_ignored();
        logic ok;
        wr_reg(4'h0, 12'hFFF, ok);
        wr_reg(4'h6, 12'hFFF, ok);
        wr_reg(4'hB, 12'hFFF, ok);
        wr_reg(4'hF, 12'hFFF, ok);
        chk(thr1 == 8'hA5 && thr2 == 0 && ana == 12'h3C7 && setup3 == 12'h812,
            "R3 ignored headers thr/ana/s3", {thr1, thr2, ana}, {8'hA5, 8'h00, 12'h3C7});
        chk(setup1 == 12'h00E && setup2 == 0 && coarse == 0 && gain == 0,
            "R3 ignored headers setup/exp", {setup1, setup2}, {12'h00E, 12'h000});
        chk(ok == 1'b1, "R3 hold not raised by ignored header", ok, 1);
    endtask

    task automatic t_pack();
        logic ok;
        wr_reg(4'h9, 12'hF5A, ok);
        chk(thr2 == 8'h5A, "R4 thr2 upper bits dropped", thr2, 8'h5A);
        wr_reg(4'h5, 12'hFF7, ok);
        pulse_frame();
        chk(gain == 4'h7, "R4 gain upper bits dropped", gain, 4'h7);
    endtask

    task automatic t_stage();
        logic ok;
        logic [31:0] w;
        wr_reg(4'h3, 12'h1AB, ok);
        chk(ok, "R5 coarse write acked", ok, 1);
        chk(coarse == 9'h000, "R5 coarse held before frame", coarse, 0);
        rd_reg(w, ok);
        chk(ok == 1'b0, "R6 read refused while pending", ok, 0);
        wr_reg(4'h8, 12'h011, ok);
        chk(ok == 1'b0 && thr1 == 8'hA5, "R6 write refused while pending", thr1, 8'hA5);
        chk(coarse == 9'h000, "R5 coarse still held", coarse, 0);
        pulse_frame();
        chk(coarse == 9'h1AB, "R5 coarse applied at frame", coarse, 9'h1AB);
        wr_reg(4'h4, 12'h055, ok);
        chk(ok, "R6 accepted after frame", ok, 1);
        pulse_frame();
        chk(fine == 9'h055, "R5 fine applied", fine, 9'h055);
    endtask

    function automatic logic [31:0] prim_exp();
        return {9'h1AB, 9'h055, 4'h7, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 4'h5};
    endfunction

    task automatic t_read_primary();
        logic ok;
        logic [31:0] w;
        rd_reg(w, ok);
        chk(ok, "R1 read address acked", ok, 1);
        chk(w == prim_exp(), "R7 primary word", w, prim_exp());
    endtask

    task automatic t_nack();
        logic ok, bb;
        logic [7:0] b;
        bus_start();
        send_byte({DEV, 1'b1}, ok);
        recv_byte(b, 1'b0);
        chk(b == prim_exp()[31:24], "R12 first byte before nack", b, prim_exp()[31:24]);
        get_bit(bb);
        chk(bb == 1'b1, "R12 line released after nack", bb, 1);
        get_bit(bb);
        chk(bb == 1'b1 && sda_pull == 1'b0, "R12 still released", bb, 1);
        bus_stop();
    endtask

    task automatic t_secondary();
        logic ok;
        logic [31:0] w;
        wr_reg(4'h2, 12'h001, ok);
        rd_reg(w, ok);
        chk(w == {14'b0, 1'b1, 17'h1ABCD}, "R8 secondary word", w, {14'b0, 1'b1, 17'h1ABCD});
        wr_reg(4'h2, 12'h000, ok);
        rd_reg(w, ok);
        chk(w == prim_exp(), "R8 back to primary", w, prim_exp());
    endtask

    task automatic t_div();
        logic ok;
        wr_reg(4'h1, 12'h300, ok);
        chk(div == 4'd8, "R10 div by 8", div, 8);
        wr_reg(4'h1, 12'h100, ok);
        chk(div == 4'd2, "R10 div by 2", div, 2);
        wr_reg(4'h1, 12'h20E, ok);
        chk(div == 4'd4 && setup1 == 12'h20E, "R10 div by 4", div, 4);
    endtask

    task automatic t_no_stop();
        logic a0, a1, a2, a3;
        bus_start();
        send_byte({DEV, 1'b0}, a0);
        send_byte(8'h80, a1);
        send_byte(8'h33, a2);
        send_byte(8'h9F, a3);
        chk(a0 & a1 & a2, "R11 two bytes acked", {a0, a1, a2}, 3'b111);
        chk(a3 == 1'b0, "R11 third byte not acked", a3, 0);
        send_byte(8'h77, a3);
        bus_stop();
        chk(thr1 == 8'h33 && thr2 == 8'h5A, "R11 extra bytes not written", {thr1, thr2}, {8'h33, 8'h5A});
    endtask

    initial begin
        wq(5);
        rst_n = 1'b1;
        wq(5);
        t_reset();
        t_address();
        t_write();
        t_ignored();
        t_pack();
        t_stage();
        t_read_primary();
        t_nack();
        t_secondary();
        t_div();
        t_no_stop();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 150000, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule